// File: doc/BRIEF.md
# Four-Level Virtual Address Translation Walker

This block turns a 64-bit virtual address into a physical address by reading a four-level radix tree of translation tables from memory. Every table is 4096 bytes and holds 512 eight-byte entries. The walk starts at the table whose base sits in a root register input. Each level picks its entry with a fixed 9-bit slice of the virtual address. The low 12 address bits pass straight through as the page offset.

A requester offers a virtual address, a write flag and a user-mode flag on a valid/ready handshake. The walker works on one request at a time. For each entry it issues a single read on a simple memory port and waits any number of cycles for the returned 64-bit entry. It ANDs the writable and user bits of all the levels it visits. At the end it reports a one-cycle result: the physical address and the combined permissions, or a fault with its cause.

Entry layout: bit 0 is present, bit 1 is writable, bit 2 is user-accessible, and bits 47:12 hold the base of the next table or of the final page frame. Cause codes: 0 no fault, 1 non-canonical address, 2 entry not present, 3 permission denied.

Top module: `va_walker`

## Requirements
- R1: Out of reset, `reqReady` is 1 and both `rspValid` and `memReqValid` are 0.
- R2: A walk that does not fault issues exactly four reads, one per level. The read address is the current table base (root bits 47:12 for the first level, then entry bits 47:12) plus 8 times the index, and the index comes from VA bits 47:39, 38:30, 29:21 and 20:12, in that order.
- R3: On success, `rspPa` holds the last entry's bits 47:12 as bits 47:12 and VA bits 11:0 as bits 11:0, with bits 63:48 zero.
- R4: If VA bits 63:48 are not all equal to VA bit 47, the result is a fault with cause 1 and no memory read is issued.
- R5: An entry at level k (1 to 4) with bit 0 clear ends the walk with cause 2 after exactly k reads.
- R6: On success, `rspPerm` bit 0 is the AND of the writable bits of all four entries and bit 1 is the AND of their user bits. On any fault, `rspPerm` and `rspPa` are 0.
- R7: A write access whose combined writable bit is 0 faults with cause 3 after four reads.
- R8: A user access whose combined user bit is 0 faults with cause 3. A supervisor access ignores the user bit.
- R9: `reqReady` is low from the cycle after a request is accepted up to and including the cycle in which `rspValid` is high. `rspValid` is a one-cycle pulse, and a request held during a walk is not taken twice.
- R10: At most one memory read is outstanding. `memReqValid` is a one-cycle pulse, and the walk waits for `memRespValid` whatever the response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request offered |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVa | input | 64 | Virtual address to translate |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access is from user mode |
| rootBase | input | 64 | Base of the top-level table; bits 47:12 are used |
| memReqValid | output | 1 | Entry read request |
| memAddr | output | 64 | Byte address of the entry to read |
| memRespValid | input | 1 | Entry data returned |
| memRespData | input | 64 | Returned 64-bit entry |
| rspValid | output | 1 | Result pulse |
| rspPa | output | 64 | Translated physical address |
| rspPerm | output | 2 | Combined permissions: bit 1 user, bit 0 writable |
| rspFault | output | 1 | Walk ended in a fault |
| rspCause | output | 2 | Fault cause code |

## Verification
The hardest outcome to reach is a fault at each depth of the walk, where the read count must equal the level that failed, together with permission denials that appear only after all four levels have been combined. The bench builds a sparse in-memory tree with paths that share upper tables and diverge at chosen levels. One path clears the writable bit at level two and another clears the user bit at level three, and empty slots stop walks at levels one to four. Each path is run in user and supervisor mode, with reads and writes, at both one-cycle and three-cycle memory latency. A request is also held high across a busy walk to check that it is taken only once.

// File: rtl/walk_pkg.sv
package walk_pkg;
  parameter int VA_W   = 64;
  parameter int PA_W   = 48;
  parameter int LEVELS = 4;
  parameter int IDX_W  = 9;
  parameter int OFF_W  = 12;

  localparam int ENT_B  = OFF_W - IDX_W;
  localparam int VA_SIG = OFF_W + IDX_W * LEVELS;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int CNT_W  = LVL_W + 1;
  localparam int BASE_W = PA_W - OFF_W;

  localparam int ENT_PRESENT = 0;
  localparam int ENT_WRITE   = 1;
  localparam int ENT_USER    = 2;
  localparam int PERM_WR     = 0;
  localparam int PERM_US     = 1;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_NONCANON = 2'd1,
    CAUSE_ABSENT   = 2'd2,
    CAUSE_PERM     = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_e;

  typedef struct packed {
    logic load;
    logic issue;
    logic capture;
    logic respond;
  } walk_strobe_t;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memRespValid,
  input  logic         canonical,
  input  logic         entryPresent,
  input  logic         lastLevel,
  output logic         reqReady,
  output walk_strobe_t strobe
);
  walk_state_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (reqValid) stateD = canonical ? ST_ISSUE : ST_DONE;
      ST_ISSUE: stateD = ST_WAIT;
      ST_WAIT:  if (memRespValid) stateD = (!entryPresent || lastLevel) ? ST_DONE : ST_ISSUE;
      ST_DONE:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady        = (stateQ == ST_IDLE);
  assign strobe.load     = (stateQ == ST_IDLE) && reqValid;
  assign strobe.issue    = (stateQ == ST_ISSUE);
  assign strobe.capture  = (stateQ == ST_WAIT) && memRespValid;
  assign strobe.respond  = (stateQ == ST_DONE);

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.respond |=> !strobe.respond); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R9
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |=> !strobe.issue); // R10
  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> !reqReady); // R10
endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walk_strobe_t      strobe,
  input  logic [VA_W-1:0]   reqVa,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic [VA_W-1:0]   rootBase,
  input  logic [VA_W-1:0]   memRespData,
  output logic              canonical,
  output logic              entryPresent,
  output logic              lastLevel,
  output logic [VA_W-1:0]   memAddr,
  output logic [VA_W-1:0]   rspPa,
  output logic [1:0]        rspPerm,
  output logic              rspFault,
  output cause_e            rspCause
);
  logic [VA_W-1:0]   vaQ;
  logic              writeQ, userQ;
  logic [LVL_W-1:0]  levelQ;
  logic [BASE_W-1:0] baseQ;
  logic [1:0]        permQ;
  cause_e            causeQ;
  logic [CNT_W-1:0]  readCntQ;

  logic [VA_W-VA_SIG:0] vaUpper;
  assign vaUpper   = reqVa[VA_W-1:VA_SIG-1];
  assign canonical = (&vaUpper) || !(|vaUpper);

  logic [IDX_W-1:0] idxAt [LEVELS];
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idxAt[g] = vaQ[OFF_W + IDX_W * (LEVELS - 1 - g) +: IDX_W];
  end

  logic [IDX_W-1:0] idxSel;
  assign idxSel    = idxAt[levelQ];
  assign memAddr   = {{(VA_W-PA_W){1'b0}}, baseQ, idxSel, {ENT_B{1'b0}}};
  assign lastLevel = (levelQ == LVL_W'(LEVELS - 1));
  assign entryPresent = memRespData[ENT_PRESENT];

  logic [1:0] permMerged;
  logic       permDenied;
  always_comb begin
    permMerged = permQ;
    permMerged[PERM_WR] = permQ[PERM_WR] & memRespData[ENT_WRITE];
    permMerged[PERM_US] = permQ[PERM_US] & memRespData[ENT_USER];
    permDenied = (writeQ && !permMerged[PERM_WR]) || (userQ && !permMerged[PERM_US]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ      <= '0;
      writeQ   <= 1'b0;
      userQ    <= 1'b0;
      levelQ   <= '0;
      baseQ    <= '0;
      permQ    <= '0;
      causeQ   <= CAUSE_NONE;
      readCntQ <= '0;
    end else begin
      if (strobe.load) begin
        vaQ      <= reqVa;
        writeQ   <= reqWrite;
        userQ    <= reqUser;
        levelQ   <= '0;
        baseQ    <= rootBase[PA_W-1:OFF_W];
        permQ    <= 2'b11;
        causeQ   <= canonical ? CAUSE_NONE : CAUSE_NONCANON;
        readCntQ <= '0;
      end
      if (strobe.issue) readCntQ <= readCntQ + 1'b1;
      if (strobe.capture) begin
        if (!entryPresent) begin
          causeQ <= CAUSE_ABSENT;
        end else begin
          permQ <= permMerged;
          baseQ <= memRespData[PA_W-1:OFF_W];
          if (lastLevel) begin
            if (permDenied) causeQ <= CAUSE_PERM;
          end else begin
            levelQ <= levelQ + 1'b1;
          end
        end
      end
    end
  end

  assign rspFault = (causeQ != CAUSE_NONE);
  assign rspCause = causeQ;
  assign rspPa    = rspFault ? '0 : {{(VA_W-PA_W){1'b0}}, baseQ, vaQ[OFF_W-1:0]};
  assign rspPerm  = rspFault ? 2'b00 : permQ;

  AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> (readCntQ < CNT_W'(LEVELS))); // R2
  AST_FULL_WALK_READS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.respond && (causeQ == CAUSE_NONE || causeQ == CAUSE_PERM)) |-> (readCntQ == CNT_W'(LEVELS))); // R2
  AST_NONCANON_NOREAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.respond && causeQ == CAUSE_NONCANON) |-> (readCntQ == '0)); // R4
  AST_ABSENT_READS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.respond && causeQ == CAUSE_ABSENT) |-> (readCntQ == CNT_W'(levelQ) + 1'b1)); // R5
endmodule

// File: rtl/va_walker.sv
module va_walker
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [63:0] reqVa,
  input  logic        reqWrite,
  input  logic        reqUser,
  input  logic [63:0] rootBase,
  output logic        memReqValid,
  output logic [63:0] memAddr,
  input  logic        memRespValid,
  input  logic [63:0] memRespData,
  output logic        rspValid,
  output logic [63:0] rspPa,
  output logic [1:0]  rspPerm,
  output logic        rspFault,
  output logic [1:0]  rspCause
);
  walk_strobe_t strobe;
  logic   canonical, entryPresent, lastLevel;
  cause_e causeOut;

  walk_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .memRespValid (memRespValid),
    .canonical    (canonical),
    .entryPresent (entryPresent),
    .lastLevel    (lastLevel),
    .reqReady     (reqReady),
    .strobe       (strobe)
  );

  walk_dpath u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqVa        (reqVa),
    .reqWrite     (reqWrite),
    .reqUser      (reqUser),
    .rootBase     (rootBase),
    .memRespData  (memRespData),
    .canonical    (canonical),
    .entryPresent (entryPresent),
    .lastLevel    (lastLevel),
    .memAddr      (memAddr),
    .rspPa        (rspPa),
    .rspPerm      (rspPerm),
    .rspFault     (rspFault),
    .rspCause     (causeOut)
  );

  assign memReqValid = strobe.issue;
  assign rspValid    = strobe.respond;
  assign rspCause    = causeOut;
endmodule

// File: tb/va_walker_tb.sv
module va_walker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqVa = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic [63:0] rootBase = 64'h1000;
  logic        memReqValid;
  logic [63:0] memAddr;
  logic        memRespValid = 1'b0;
  logic [63:0] memRespData = '0;
  logic        rspValid;
  logic [63:0] rspPa;
  logic [1:0]  rspPerm;
  logic        rspFault;
  logic [1:0]  rspCause;

  always #2 clk = ~clk;

  va_walker u_dut (.*);

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  logic [63:0] memArr [logic [63:0]];
  logic [63:0] expAddr [$];
  logic [63:0] expPa [$];
  logic [1:0]  expPerm [$];
  logic [1:0]  expCause [$];
  int          expReads [$];
  bit          busy = 0;
  int          rdCnt = 0;
  int          memLat = 1;
  int          pendCnt = 0;
  logic [63:0] pendAddr = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] memRd(input logic [63:0] a);
    return memArr.exists(a) ? memArr[a] : 64'h0;
  endfunction

  function automatic logic [63:0] mkVa(input int i4, input int i3, input int i2,
                                       input int i1, input int off);
    logic [63:0] v;
    v = (64'(i4) << 39) | (64'(i3) << 30) | (64'(i2) << 21) | (64'(i1) << 12) | 64'(off);
    if (v[47]) v[63:48] = 16'hFFFF;
    return v;
  endfunction

  // Behavioural reference walk: pushes expected read addresses and the result
  task automatic refWalk(input logic [63:0] va, input bit wr, input bit us);
    logic [63:0] base, e, a;
    bit pw, pu;
    int n;
    base = rootBase & 64'h0000_FFFF_FFFF_F000;
    pw = 1; pu = 1; n = 0;
    if (va[63:48] != {16{va[47]}}) begin
      expPa.push_back(0); expPerm.push_back(0); expCause.push_back(2'd1); expReads.push_back(0);
      return;
    end
    for (int lvl = 0; lvl < 4; lvl++) begin
      a = base + (((va >> (39 - 9 * lvl)) & 64'h1FF) * 8);
      expAddr.push_back(a);
      n++;
      e = memRd(a);
      if (!e[0]) begin
        expPa.push_back(0); expPerm.push_back(0); expCause.push_back(2'd2); expReads.push_back(n);
        return;
      end
      pw = pw & e[1];
      pu = pu & e[2];
      base = e & 64'h0000_FFFF_FFFF_F000;
    end
    if ((wr && !pw) || (us && !pu)) begin
      expPa.push_back(0); expPerm.push_back(0); expCause.push_back(2'd3); expReads.push_back(4);
    end else begin
      expPa.push_back(base | (va & 64'hFFF)); expPerm.push_back({pu, pw});
      expCause.push_back(2'd0); expReads.push_back(4);
    end
  endtask

  // Monitor and reference model at the active edge (pre-update values)
  always @(posedge clk) begin
    if (rstN && !finished) begin
      if (memReqValid) begin
        rdCnt++;
        if (expAddr.size() == 0) check(0, "R2", "unexpected read", memAddr, 0);
        else begin
          logic [63:0] ea;
          ea = expAddr.pop_front();
          check(memAddr == ea, "R2", "read address", memAddr, ea);
        end
        check(pendCnt == 0, "R10", "read while outstanding", 64'(pendCnt), 0);
        pendAddr = memAddr;
        pendCnt = memLat;
      end
      if (rspValid) begin
        if (expPa.size() == 0) check(0, "R9", "unexpected response", 1, 0);
        else begin
          logic [63:0] pa; logic [1:0] pm, cs; int nr;
          pa = expPa.pop_front(); pm = expPerm.pop_front();
          cs = expCause.pop_front(); nr = expReads.pop_front();
          check(rspCause == cs, (cs == 1) ? "R4" : (cs == 2) ? "R5" : (cs == 3) ? "R7/R8" : "R2",
                "cause", 64'(rspCause), 64'(cs));
          check(rspFault == (cs != 0), "R5", "fault flag", 64'(rspFault), 64'(cs != 0));
          check(rspPa == pa, "R3", "physical address", rspPa, pa);
          check(rspPerm == pm, "R6", "permissions", 64'(rspPerm), 64'(pm));
          check(rdCnt == nr, (cs == 1) ? "R4" : "R5", "read count", 64'(rdCnt), 64'(nr));
        end
        busy = 0;
      end
      if (reqValid && reqReady) begin
        busy = 1;
        rdCnt = 0;
        refWalk(reqVa, reqWrite, reqUser);
      end
    end
  end

  // Ready comparison on every cycle and memory response drive
  bit lastRsp = 0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(reqReady == !busy, "R9", "ready vs busy", 64'(reqReady), 64'(!busy));
      if (lastRsp) check(!rspValid, "R9", "response pulse", 64'(rspValid), 0);
      lastRsp = rspValid;
      memRespValid = 1'b0;
      if (pendCnt > 0) begin
        pendCnt--;
        if (pendCnt == 0) begin
          memRespValid = 1'b1;
          memRespData = memRd(pendAddr);
        end
      end
    end
  end

  task automatic doReq(input logic [63:0] va, input bit wr, input bit us);
    @(negedge clk);
    reqVa = va; reqWrite = wr; reqUser = us; reqValid = 1'b1;
    do @(posedge clk); while (!reqReady);
    @(negedge clk);
    reqValid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic runAll();
    // R2 R3 R6: full walk, all levels writable and user
    doReq(mkVa(1, 2, 3, 4, 12'h123), 0, 1);
    doReq(mkVa(1, 2, 3, 4, 12'hFFF), 1, 1);
    // upper-half canonical address reaching the same page
    doReq(mkVa(256, 2, 3, 4, 12'h045), 1, 0);
    // R7: level-two entry read-only
    doReq(mkVa(1, 5, 0, 0, 12'h456), 0, 1);
    doReq(mkVa(1, 5, 0, 0, 12'h456), 1, 1);
    doReq(mkVa(1, 5, 0, 0, 12'h456), 1, 0);
    // R8: level-three entry kernel-only
    doReq(mkVa(1, 2, 6, 7, 12'h010), 0, 1);
    doReq(mkVa(1, 2, 6, 7, 12'h010), 1, 0);
    // R5: absent at levels 4, 3, 2, 1
    doReq(mkVa(1, 2, 3, 9, 0), 0, 0);
    doReq(mkVa(1, 2, 8, 0, 0), 0, 0);
    doReq(mkVa(1, 9, 0, 0, 0), 0, 0);
    doReq(mkVa(2, 0, 0, 0, 0), 0, 0);
    // R4: non-canonical in both directions
    doReq(64'h0001_0000_0000_1000, 0, 0);
    doReq(64'hFFFF_0000_0000_1000, 0, 0);
    doReq(64'h7FFF_8000_0000_0000, 1, 1);
  endtask

  initial begin
    // sparse tree: flags P=1 W=2 U=4
    memArr[64'h1000 + 1 * 8]   = 64'h2000 | 7;
    memArr[64'h1000 + 256 * 8] = 64'h2000 | 7;
    memArr[64'h2000 + 2 * 8]   = 64'h3000 | 7;
    memArr[64'h3000 + 3 * 8]   = 64'h4000 | 7;
    memArr[64'h4000 + 4 * 8]   = 64'h0000_7654_3210_F000 | 7;
    memArr[64'h2000 + 5 * 8]   = 64'h5000 | 5;
    memArr[64'h5000]           = 64'h6000 | 7;
    memArr[64'h6000]           = 64'hFFFF_0000_0ABC_D000 | 7;
    memArr[64'h3000 + 6 * 8]   = 64'h7000 | 3;
    memArr[64'h7000 + 7 * 8]   = 64'h9999_8000 | 7;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(reqReady == 1'b1, "R1", "ready in reset", 64'(reqReady), 1);
    check(rspValid == 1'b0, "R1", "response in reset", 64'(rspValid), 0);
    check(memReqValid == 1'b0, "R1", "read in reset", 64'(memReqValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready after reset", 64'(reqReady), 1);

    memLat = 1;
    runAll();
    // R10: slow memory
    memLat = 3;
    runAll();

    // R9: request held high across a busy walk, then a second request
    memLat = 2;
    @(negedge clk);
    reqVa = mkVa(1, 2, 3, 4, 12'h001); reqWrite = 0; reqUser = 1; reqValid = 1'b1;
    do @(posedge clk); while (!reqReady);
    @(negedge clk);
    reqVa = mkVa(1, 2, 6, 7, 12'h002); reqUser = 0;
    do @(posedge clk); while (!reqReady);
    @(negedge clk);
    reqValid = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(expPa.size() == 0, "R9", "pending results", 64'(expPa.size()), 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual=%0d expected=below 20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule